// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block gathers 64 interrupt lines into two request outputs for a processor: a normal request and a fast request. Each line can be treated as level-sensitive or edge-sensitive. Edge lines can catch rising edges, falling edges or both, and hold the event in a sticky latch until software clears it. Software can also raise any line itself through a soft trigger. Each line can be enabled or masked, and can be steered to either output.

Software reaches the block through a single-cycle word-addressed register port. Each register function has two words: one for sources 0 to 31 (low bank) and one for sources 32 to 63 (high bank). Address bit 0 picks the bank and bits 5:1 pick the function. A handler reads the masked normal-request status of the low bank first, then the high bank if the low bank is zero, and services the lowest set bit.

Top module: `intc_dualbank`

## Requirements
- R1: After reset, enable, soft trigger, select, dual-edge, edge-polarity and edge latch state are all zero, both outputs are low, and the level map reads back the `LEVEL_INIT` parameter (default 0xFFFF0000 in each bank).
- R2: Word address = 2*function + bank, with bank 0 = sources 0..31 and bank 1 = sources 32..63. The function codes are: 0 normal status, 1 fast status, 2 raw status, 3 select, 4 enable-set, 5 enable-clear, 6 trigger-set, 7 trigger-clear, 8 level map, 9 dual-edge, 10 edge polarity, 11 edge-clear, 12 edge latch. A write to one bank leaves the other bank unchanged.
- R3: Writing 1s to enable-set enables those sources, and writing 1s to enable-clear disables them. 0 bits leave the state unchanged. Both addresses read back the enable state.
- R4: Trigger-set and trigger-clear act on the soft trigger bits in the same write-one way. Both addresses read back the trigger state.
- R5: With select bit 0 a source feeds the normal status. With select bit 1 it feeds the fast status. Normal status = raw & enable & ~select, and fast status = raw & enable & select.
- R6: Raw status is the source term OR the soft trigger, taken before masking.
- R7: For a level source (level-map bit 1), the source term follows the input after the two-flop synchronizer. No latch is involved.
- R8: For an edge source (level-map bit 0) with dual-edge 0, polarity bit 1 latches on a rising edge and 0 latches on a falling edge. An edge of the other polarity is ignored. The latch stays set until it is cleared.
- R9: With dual-edge 1, an edge source latches on both rising and falling transitions.
- R10: Writing 1s to edge-clear clears those latches, and 0 bits leave latches alone. Edge-clear on a level source does not change its raw status.
- R11: The normal output is high exactly when any normal status bit in either bank is set, and the fast output likewise for fast status.
- R12: The level map is read-only. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| waddr_i | input | 6 | Word address: {function, bank} |
| wr_en_i | input | 1 | Write strobe, acts on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for waddr_i, combinational |
| src_i | input | 64 | Interrupt input lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The case hardest to reach from the ports is telling the edge polarities apart. After reset every edge source waits for a falling edge, so the stimulus first raises a line and shows that the latch stays empty, then drops it and shows the latch fill. It then reprograms the polarity and repeats the pair in the other order. Dual-edge capture is proven on a high-bank line by clearing the latch between its rise and its fall. This also shows the low bank reading zero while the high bank requests.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W  = 32;
    localparam int NBANK   = 2;
    localparam int NSRC    = DATA_W * NBANK;
    localparam int FN_W    = 5;
    localparam int WADDR_W = FN_W + 1;

    typedef enum logic [FN_W-1:0] {
        FN_IRQ_ST   = 5'd0,
        FN_FIQ_ST   = 5'd1,
        FN_RAW      = 5'd2,
        FN_SEL      = 5'd3,
        FN_EN_SET   = 5'd4,
        FN_EN_CLR   = 5'd5,
        FN_TRG_SET  = 5'd6,
        FN_TRG_CLR  = 5'd7,
        FN_LEVEL    = 5'd8,
        FN_DUAL     = 5'd9,
        FN_POL      = 5'd10,
        FN_EDGE_CLR = 5'd11,
        FN_EDGE_ST  = 5'd12
    } fn_e;

    typedef struct packed {
        fn_e  fn;
        logic bank;
    } reg_sel_t;

    typedef struct packed {
        logic [NSRC-1:0] sel;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] trig;
        logic [NSRC-1:0] dual;
        logic [NSRC-1:0] pol;
    } cfg_t;

    function automatic reg_sel_t decode(input logic [WADDR_W-1:0] wa);
        reg_sel_t r;
        r.fn   = fn_e'(wa[WADDR_W-1:1]);
        r.bank = wa[0];
        return r;
    endfunction

    function automatic logic [NSRC-1:0] spread(input logic bank, input logic [DATA_W-1:0] d);
        return bank ? {d, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, d};
    endfunction

    function automatic logic [DATA_W-1:0] half(input logic bank, input logic [NSRC-1:0] v);
        return bank ? v[NSRC-1:DATA_W] : v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/intc_edge_latch.sv
module intc_edge_latch #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] dual_i,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line_i;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic up, dn;
            assign up = line_i[i] & ~prev_q[i];
            assign dn = ~line_i[i] & prev_q[i];
            assign hit[i] = ~level_i[i] &
                            (dual_i[i] ? (up | dn) : (rise_i[i] ? up : dn));
        end
    endgenerate

    // a new event in the same cycle as a clear is kept
    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= (lat_q & ~clr_i) | hit;
    end

    assign lat_o = lat_q;

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lat_q & $past(lat_q & ~clr_i)) == $past(lat_q & ~clr_i)));

    // R10
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lat_q & $past(clr_i & ~hit)) == '0));
endmodule

// File: rtl/intc_dualbank.sv
module intc_dualbank
    import intc_pkg::*;
#(
    parameter logic [NSRC-1:0] LEVEL_INIT = 64'hFFFF_0000_FFFF_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WADDR_W-1:0] waddr_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NSRC-1:0]    src_i,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam logic [NSRC-1:0] LEVEL_MAP = LEVEL_INIT;

    reg_sel_t        rs;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] bank_mask;
    cfg_t            cfg_q;
    logic [NSRC-1:0] line_s;
    logic [NSRC-1:0] lat;
    logic [NSRC-1:0] edge_clr;
    logic [NSRC-1:0] src_term;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] irq_st;
    logic [NSRC-1:0] fiq_st;

    assign rs        = decode(waddr_i);
    assign wmask     = spread(rs.bank, wdata_i);
    assign bank_mask = spread(rs.bank, {DATA_W{1'b1}});

    function automatic logic hit_fn(input fn_e f);
        return wr_en_i && (rs.fn == f);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (hit_fn(FN_SEL))     cfg_q.sel  <= (cfg_q.sel  & ~bank_mask) | wmask;
            if (hit_fn(FN_DUAL))    cfg_q.dual <= (cfg_q.dual & ~bank_mask) | wmask;
            if (hit_fn(FN_POL))     cfg_q.pol  <= (cfg_q.pol  & ~bank_mask) | wmask;
            if (hit_fn(FN_EN_SET))  cfg_q.en   <= cfg_q.en | wmask;
            if (hit_fn(FN_EN_CLR))  cfg_q.en   <= cfg_q.en & ~wmask;
            if (hit_fn(FN_TRG_SET)) cfg_q.trig <= cfg_q.trig | wmask;
            if (hit_fn(FN_TRG_CLR)) cfg_q.trig <= cfg_q.trig & ~wmask;
        end
    end

    assign edge_clr = hit_fn(FN_EDGE_CLR) ? wmask : '0;

    intc_sync #(.W(NSRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (line_s)
    );

    intc_edge_latch #(.W(NSRC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line_s),
        .level_i (LEVEL_MAP),
        .dual_i  (cfg_q.dual),
        .rise_i  (cfg_q.pol),
        .clr_i   (edge_clr),
        .lat_o   (lat)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign src_term[i] = LEVEL_MAP[i] ? line_s[i] : lat[i];
        end
    endgenerate

    assign raw    = src_term | cfg_q.trig;
    assign irq_st = raw & cfg_q.en & ~cfg_q.sel;
    assign fiq_st = raw & cfg_q.en & cfg_q.sel;
    assign irq_o  = |irq_st;
    assign fiq_o  = |fiq_st;

    always_comb begin
        unique case (rs.fn)
            FN_IRQ_ST:              rdata_o = half(rs.bank, irq_st);
            FN_FIQ_ST:              rdata_o = half(rs.bank, fiq_st);
            FN_RAW:                 rdata_o = half(rs.bank, raw);
            FN_SEL:                 rdata_o = half(rs.bank, cfg_q.sel);
            FN_EN_SET, FN_EN_CLR:   rdata_o = half(rs.bank, cfg_q.en);
            FN_TRG_SET, FN_TRG_CLR: rdata_o = half(rs.bank, cfg_q.trig);
            FN_LEVEL:               rdata_o = half(rs.bank, LEVEL_MAP);
            FN_DUAL:                rdata_o = half(rs.bank, cfg_q.dual);
            FN_POL:                 rdata_o = half(rs.bank, cfg_q.pol);
            FN_EDGE_ST:             rdata_o = half(rs.bank, lat);
            default:                rdata_o = '0;
        endcase
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && rs.fn == FN_EN_SET) |=> ((cfg_q.en & $past(wmask)) == $past(wmask)));

    // R4
    trg_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && rs.fn == FN_TRG_CLR) |=> ((cfg_q.trig & $past(wmask)) == '0));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en == '0) |-> (!irq_o && !fiq_o));

    // R11
    one_route_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.sel == '0) |-> !fiq_o));
endmodule

// File: tb/intc_dualbank_test.sv
module intc_dualbank_test;
    localparam int CLK_P = 10;

    localparam logic [5:0] A_IRQ_L = 6'd0,  A_IRQ_H = 6'd1;
    localparam logic [5:0] A_FIQ_H = 6'd3;
    localparam logic [5:0] A_RAW_L = 6'd4,  A_RAW_H = 6'd5;
    localparam logic [5:0] A_SEL_L = 6'd6,  A_SEL_H = 6'd7;
    localparam logic [5:0] A_ENS_L = 6'd8,  A_ENS_H = 6'd9;
    localparam logic [5:0] A_ENC_L = 6'd10, A_ENC_H = 6'd11;
    localparam logic [5:0] A_TGS_H = 6'd13, A_TGC_L = 6'd14, A_TGC_H = 6'd15;
    localparam logic [5:0] A_LVL_L = 6'd16, A_LVL_H = 6'd17;
    localparam logic [5:0] A_DUA_H = 6'd19, A_POL_L = 6'd20;
    localparam logic [5:0] A_ECL_L = 6'd22, A_ECL_H = 6'd23;
    localparam logic [5:0] A_EST_L = 6'd24, A_EST_H = 6'd25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  waddr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] src = '0;
    logic        irq, fiq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0]  a;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    intc_dualbank uut (
        .clk     (clk),
        .rst     (rst),
        .waddr_i (waddr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .src_i   (src),
        .irq_o   (irq),
        .fiq_o   (fiq)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        waddr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = 1'b0; waddr = a;
        it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic outs(input logic ei, input logic ef, input string tag);
        @(negedge clk);
        #(CLK_P/4);
        n_chk++;
        if (irq !== ei || fiq !== ef) begin
            n_fail++;
            $display("FAIL %s outputs irq=%b fiq=%b expected irq=%b fiq=%b", tag, irq, fiq, ei, ef);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    // monitor: pops expected reads and compares them
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_chk++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d got=%h expected=%h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_ENS_L, 32'h0, "R1 enable low");
        rd(A_SEL_H, 32'h0, "R1 select high");
        rd(A_TGC_L, 32'h0, "R1 trigger low");
        rd(A_EST_L, 32'h0, "R1 edge latch low");
        rd(A_LVL_L, 32'hFFFF_0000, "R1 level map low");
        rd(A_LVL_H, 32'hFFFF_0000, "R1 level map high");
        outs(1'b0, 1'b0, "R1");

        // R12 level map ignores writes
        wr(A_LVL_L, 32'h0000_1234);
        rd(A_LVL_L, 32'hFFFF_0000, "R12 level map write ignored");

        // R3 enable set and clear
        wr(A_ENS_L, 32'h0000_00F0);
        rd(A_ENS_L, 32'h0000_00F0, "R3 enable set");
        wr(A_ENS_L, 32'h0000_000F);
        rd(A_ENS_L, 32'h0000_00FF, "R3 enable set keeps old bits");
        wr(A_ENC_L, 32'h0000_0030);
        rd(A_ENC_L, 32'h0000_00CF, "R3 enable clear");

        // R2 bank separation
        wr(A_SEL_L, 32'h0000_0005);
        rd(A_SEL_H, 32'h0, "R2 high select untouched");
        rd(A_SEL_L, 32'h0000_0005, "R2 low select");
        wr(A_SEL_L, 32'h0);

        // R4 / R6 soft trigger, raw before masking
        wr(A_TGS_H, 32'h8000_0001);
        rd(A_TGC_H, 32'h8000_0001, "R4 trigger set");
        rd(A_RAW_H, 32'h8000_0001, "R6 raw from trigger");
        rd(A_IRQ_H, 32'h0, "R6 masked status zero");
        outs(1'b0, 1'b0, "R6 masked");
        wr(A_ENS_H, 32'h0000_0001);
        rd(A_IRQ_H, 32'h0000_0001, "R5 normal status");
        outs(1'b1, 1'b0, "R11 normal output");
        // R5 routing to fast
        wr(A_SEL_H, 32'h0000_0001);
        rd(A_IRQ_H, 32'h0, "R5 normal status after select");
        rd(A_FIQ_H, 32'h0000_0001, "R5 fast status");
        outs(1'b0, 1'b1, "R11 fast output");
        wr(A_TGC_H, 32'h8000_0001);
        rd(A_RAW_H, 32'h0, "R4 trigger clear");
        outs(1'b0, 1'b0, "R4 outputs after clear");
        wr(A_SEL_H, 32'h0);
        wr(A_ENC_H, 32'hFFFF_FFFF);
        wr(A_ENC_L, 32'hFFFF_FFFF);

        // R7 level source 20
        src[20] = 1'b1;
        settle();
        rd(A_RAW_L, 32'h0010_0000, "R7 level raw high");
        rd(A_EST_L, 32'h0, "R7 no latch");
        wr(A_ENS_L, 32'h0010_0000);
        outs(1'b1, 1'b0, "R7 level drives output");
        wr(A_ECL_L, 32'h0010_0000);
        rd(A_RAW_L, 32'h0010_0000, "R10 clear on level source");
        src[20] = 1'b0;
        settle();
        rd(A_RAW_L, 32'h0, "R7 level follows input low");
        outs(1'b0, 1'b0, "R7 output drops");
        wr(A_ENC_L, 32'hFFFF_FFFF);

        // R8 falling edge by default on source 3
        src[3] = 1'b1;
        settle();
        rd(A_EST_L, 32'h0, "R8 rise ignored at polarity 0");
        src[3] = 1'b0;
        settle();
        rd(A_EST_L, 32'h0000_0008, "R8 fall latched");
        settle();
        rd(A_RAW_L, 32'h0000_0008, "R8 latch sticky");
        wr(A_ECL_L, 32'h0000_0001);
        rd(A_EST_L, 32'h0000_0008, "R10 zero bits keep latch");
        wr(A_ECL_L, 32'h0000_0008);
        rd(A_EST_L, 32'h0, "R10 latch cleared");

        // R8 rising edge with polarity 1
        wr(A_POL_L, 32'h0000_0008);
        src[3] = 1'b1;
        settle();
        rd(A_EST_L, 32'h0000_0008, "R8 rise latched");
        wr(A_ECL_L, 32'h0000_0008);
        src[3] = 1'b0;
        settle();
        rd(A_EST_L, 32'h0, "R8 fall ignored at polarity 1");

        // R9 dual edge on source 40
        wr(A_DUA_H, 32'h0000_0100);
        src[40] = 1'b1;
        settle();
        rd(A_EST_H, 32'h0000_0100, "R9 rise latched");
        wr(A_ECL_H, 32'h0000_0100);
        rd(A_EST_H, 32'h0, "R9 cleared");
        src[40] = 1'b0;
        settle();
        rd(A_EST_H, 32'h0000_0100, "R9 fall latched");
        wr(A_ENS_H, 32'h0000_0100);
        rd(A_IRQ_L, 32'h0, "R2 low bank status zero");
        rd(A_IRQ_H, 32'h0000_0100, "R2 high bank status");
        outs(1'b1, 1'b0, "R11 high bank request");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule